// File: doc/BRIEF.md
# 16-bit Segmented Address Generator

This block forms the memory address of an operand that uses the 16-bit addressing encodings. From the addressing-form byte (mode field in bits 7:6, register/memory field in bits 2:0), an already sign-extended 16-bit displacement and the eight general register values, it selects up to two base/index registers from a fixed table. It adds them to the displacement modulo 2^16 and reports which register decides the default segment. The block then applies the segment. In protected mode it adds the supplied segment base and checks the offset against the granularity-scaled segment limit. In virtual-8086 mode it builds the base from the selector times 16 and keeps 20 address bits.

The same load also decodes the default address and operand sizes of the current code segment from its long-mode and default-size descriptor bits. A result is captured one clock after `inValid` and holds until the next load. Descriptor table walks and selector loading stay outside the block. The caller supplies base, limit and granularity directly.

Top module: `agen16`

## Requirements
- R1: Register codes are AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7; `regFile[16*i+15:16*i]` holds register i. For memory forms the first register by rm value 0..7 is BX, BX, BP, BP, SI, DI, BP, BX. The second register is SI, DI, SI, DI for rm 0..3 and none for rm 4..7. `effAddr` is their sum plus the displacement, wrapped to 16 bits.
- R2: With mode 0 and rm 6 no register takes part, `effAddr` equals the displacement and `baseRegUsed` is 0.
- R3: The displacement is added for mode 1, mode 2 and the R2 case only. In mode 0 with rm other than 6 it has no effect on `effAddr`.
- R4: For every memory form other than R2, `baseReg` carries the code of the first register and `baseRegUsed` is 1.
- R5: Mode 3 is not a memory form. It sets `fault`, with `effAddr`, `linAddr` and `baseRegUsed` all 0.
- R6: In protected mode the limit is `segLimit` when `segGran` is 0 and `segLimit*4096+4095` when it is 1. `fault` is set when `effAddr` exceeds the limit, and an offset equal to the limit is legal.
- R7: In protected mode a zero `segSel` sets `fault`.
- R8: In virtual-8086 mode no limit or null-selector check applies, and `linAddr` = (`segSel`*16 + `effAddr`) mod 2^20.
- R9: In protected mode without a fault `linAddr` = (`segBase` + `effAddr`) mod 2^32. Whenever `fault` is set, `linAddr` is 0.
- R10: Size codes are 0 = 16-bit, 1 = 32-bit, 2 = 64-bit. For a code segment, {long, default} = 00 gives address/operand 0/0, 01 gives 1/1 and 10 gives 2/1. The value 11 sets `csBad` with both codes 0.
- R11: A clear code-type bit (`csIsCode` = 0) sets `csBad` with both codes 0. In virtual-8086 mode the sizes are 0/0 and `csBad` is 0 whatever the descriptor bits are.
- R12: All outputs are registered. `outValid` follows `inValid` by one clock, and results change only in the cycle after `inValid` was high. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Capture a new request |
| modrm | input | 8 | Addressing-form byte |
| disp | input | 16 | Sign-extended displacement |
| regFile | input | 128 | Eight 16-bit general registers, register i at bits 16*i+15:16*i |
| segSel | input | 16 | Segment selector value |
| segBase | input | 32 | Protected-mode segment base |
| segLimit | input | 20 | Raw segment limit |
| segGran | input | 1 | Limit counted in 4 KiB pages |
| v86Mode | input | 1 | Virtual-8086 mode |
| csIsCode | input | 1 | Code-segment descriptor type bit 3 |
| csLong | input | 1 | Code-segment long-mode bit |
| csDefault | input | 1 | Code-segment default-size bit |
| outValid | output | 1 | Result valid this cycle |
| effAddr | output | 16 | Effective offset |
| baseReg | output | 3 | Register code choosing the default segment |
| baseRegUsed | output | 1 | A register takes part in the address |
| linAddr | output | 32 | Linear address |
| fault | output | 1 | Address not usable |
| addrSize | output | 2 | Default address size code |
| opSize | output | 2 | Default operand size code |
| csBad | output | 1 | Code-segment descriptor unusable |

## Verification
The cases hardest to reach from the ports are the exact limit boundaries. A granularity-scaled limit must be hit at offset 0xFFF but not 0x1000, and a 16-bit sum must wrap below the limit while its unwrapped value lies above it. The stimulus reaches the boundaries through the displacement-only form, where the offset is the displacement alone. The wrap is produced with register pairs whose sum carries out of bit 15. Every addressing-form byte is swept in both modes against two register sets, and all code-segment bit combinations are crossed with the mode flag.

// File: rtl/agen16_pkg.sv
package agen16_pkg;

  // General register codes, fixed by the addressing encodings
  typedef enum logic [2:0] {
    GPR_AX = 3'd0, GPR_CX = 3'd1, GPR_DX = 3'd2, GPR_BX = 3'd3,
    GPR_SP = 3'd4, GPR_BP = 3'd5, GPR_SI = 3'd6, GPR_DI = 3'd7
  } gprCode_e;

  // Default size codes
  typedef enum logic [1:0] {
    SZ_16 = 2'd0, SZ_32 = 2'd1, SZ_64 = 2'd2
  } sizeCode_e;

  // Strobes from control to the datapath pieces
  typedef struct packed {
    logic eaLoad;
    logic csLoad;
  } agenStrobe_t;

  // First register of the 16-bit register-pair table
  function automatic gprCode_e firstRegOf(input logic [2:0] rm);
    case (rm)
      3'd0, 3'd1, 3'd7: firstRegOf = GPR_BX;
      3'd2, 3'd3, 3'd6: firstRegOf = GPR_BP;
      3'd4:             firstRegOf = GPR_SI;
      default:          firstRegOf = GPR_DI;
    endcase
  endfunction

endpackage

// File: rtl/agen16_ctrl.sv
module agen16_ctrl
  import agen16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output agenStrobe_t stb,
  output logic        outValid
);

  always_comb begin
    stb.eaLoad = inValid;
    stb.csLoad = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R12: one-cycle latency of the valid flag
  p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drops_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/agen16_dp.sv
module agen16_dp
  import agen16_pkg::*;
#(
  parameter int OFF_W      = 16,
  parameter int NUM_REGS   = 8,
  parameter int LIN_W      = 32,
  parameter int LIM_W      = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SEL_SHIFT  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  agenStrobe_t               stb,
  input  logic [7:0]                modrm,
  input  logic [OFF_W-1:0]          disp,
  input  logic [NUM_REGS*OFF_W-1:0] regFile,
  input  logic [OFF_W-1:0]          segSel,
  input  logic [LIN_W-1:0]          segBase,
  input  logic [LIM_W-1:0]          segLimit,
  input  logic                      segGran,
  input  logic                      v86Mode,
  output logic [OFF_W-1:0]          effAddr,
  output logic [2:0]                baseReg,
  output logic                      baseRegUsed,
  output logic [LIN_W-1:0]          linAddr,
  output logic                      fault
);

  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int SCALED_W = LIM_W + GRAN_SHIFT;
  localparam int REAL_W   = OFF_W + SEL_SHIFT;

  // Register file unpacked per register
  logic [OFF_W-1:0] gpr [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign gpr[g] = regFile[g*OFF_W +: OFF_W];
  end

  logic [1:0]       modF;
  logic [2:0]       rmF;
  logic             memForm, dispOnly, dispUse, secondUse;
  gprCode_e         firstReg, secondReg;
  logic [OFF_W-1:0] firstVal, secondVal, dispVal, eaSum;

  always_comb begin
    modF      = modrm[7:6];
    rmF       = modrm[2:0];
    memForm   = (modF != 2'd3);
    dispOnly  = (modF == 2'd0) && (rmF == 3'd6);
    dispUse   = (modF == 2'd1) || (modF == 2'd2) || dispOnly;
    secondUse = !rmF[2];
    firstReg  = firstRegOf(rmF);
    secondReg = rmF[0] ? GPR_DI : GPR_SI;
    firstVal  = dispOnly  ? '0 : gpr[IDX_W'(firstReg)];
    secondVal = secondUse ? gpr[IDX_W'(secondReg)] : '0;
    dispVal   = dispUse   ? disp : '0;
    eaSum     = firstVal + secondVal + dispVal;
  end

  // Limit scaling and checks
  logic [SCALED_W-1:0] scaledLimit;
  logic [LIN_W-1:0]    effLimit;
  logic                overLimit, nullSel, faultNext;

  always_comb begin
    scaledLimit = {segLimit, {GRAN_SHIFT{1'b1}}};
    effLimit    = segGran ? LIN_W'(scaledLimit) : LIN_W'(segLimit);
    overLimit   = !v86Mode && (LIN_W'(eaSum) > effLimit);
    nullSel     = !v86Mode && (segSel == '0);
    faultNext   = !memForm || overLimit || nullSel;
  end

  // Linear address for both modes
  logic [REAL_W-1:0] realSum;
  logic [LIN_W-1:0]  protSum, linNext;

  always_comb begin
    realSum = {segSel, {SEL_SHIFT{1'b0}}} + REAL_W'(eaSum);
    protSum = segBase + LIN_W'(eaSum);
    if (faultNext)    linNext = '0;
    else if (v86Mode) linNext = LIN_W'(realSum);
    else              linNext = protSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr     <= '0;
      baseReg     <= '0;
      baseRegUsed <= 1'b0;
      linAddr     <= '0;
      fault       <= 1'b0;
    end else if (stb.eaLoad) begin
      effAddr     <= memForm ? eaSum : '0;
      baseReg     <= (memForm && !dispOnly) ? 3'(firstReg) : 3'd0;
      baseRegUsed <= memForm && !dispOnly;
      linAddr     <= linNext;
      fault       <= faultNext;
    end
  end

  p_disp_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.eaLoad && modrm[7:6] == 2'd0 && modrm[2:0] == 3'd6
      |=> effAddr == $past(disp) && !baseRegUsed);
  p_reg_form_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.eaLoad && modrm[7:6] == 2'd3 |=> fault && linAddr == '0);
  p_null_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.eaLoad && !v86Mode && segSel == '0 |=> fault);
  p_real_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.eaLoad && v86Mode |=> linAddr[LIN_W-1:REAL_W] == '0);
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> linAddr == '0);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !stb.eaLoad |=> $stable(effAddr) && $stable(linAddr) && $stable(fault));

endmodule

// File: rtl/agen16_csdec.sv
module agen16_csdec
  import agen16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  agenStrobe_t stb,
  input  logic        v86Mode,
  input  logic        csIsCode,
  input  logic        csLong,
  input  logic        csDefault,
  output logic [1:0]  addrSize,
  output logic [1:0]  opSize,
  output logic        csBad
);

  sizeCode_e addrNext, opNext;
  logic      badNext;

  always_comb begin
    addrNext = SZ_16;
    opNext   = SZ_16;
    badNext  = 1'b0;
    if (!v86Mode) begin
      if (!csIsCode) begin
        badNext = 1'b1;
      end else begin
        case ({csLong, csDefault})
          2'b00: begin addrNext = SZ_16; opNext = SZ_16; end
          2'b01: begin addrNext = SZ_32; opNext = SZ_32; end
          2'b10: begin addrNext = SZ_64; opNext = SZ_32; end
          default: badNext = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrSize <= '0;
      opSize   <= '0;
      csBad    <= 1'b0;
    end else if (stb.csLoad) begin
      addrSize <= addrNext;
      opSize   <= opNext;
      csBad    <= badNext;
    end
  end

  p_data_seg_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.csLoad && !v86Mode && !csIsCode |=> csBad && addrSize == 2'd0);
  p_v86_sizes_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.csLoad && v86Mode |=> !csBad && addrSize == 2'd0 && opSize == 2'd0);
  p_both_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.csLoad && !v86Mode && csLong && csDefault |=> csBad);

endmodule

// File: rtl/agen16.sv
module agen16
  import agen16_pkg::*;
#(
  parameter int OFF_W      = 16,
  parameter int NUM_REGS   = 8,
  parameter int LIN_W      = 32,
  parameter int LIM_W      = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SEL_SHIFT  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [7:0]                modrm,
  input  logic [OFF_W-1:0]          disp,
  input  logic [NUM_REGS*OFF_W-1:0] regFile,
  input  logic [OFF_W-1:0]          segSel,
  input  logic [LIN_W-1:0]          segBase,
  input  logic [LIM_W-1:0]          segLimit,
  input  logic                      segGran,
  input  logic                      v86Mode,
  input  logic                      csIsCode,
  input  logic                      csLong,
  input  logic                      csDefault,
  output logic                      outValid,
  output logic [OFF_W-1:0]          effAddr,
  output logic [2:0]                baseReg,
  output logic                      baseRegUsed,
  output logic [LIN_W-1:0]          linAddr,
  output logic                      fault,
  output logic [1:0]                addrSize,
  output logic [1:0]                opSize,
  output logic                      csBad
);

  agenStrobe_t stb;

  agen16_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  agen16_dp #(
    .OFF_W(OFF_W), .NUM_REGS(NUM_REGS), .LIN_W(LIN_W),
    .LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT), .SEL_SHIFT(SEL_SHIFT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .modrm       (modrm),
    .disp        (disp),
    .regFile     (regFile),
    .segSel      (segSel),
    .segBase     (segBase),
    .segLimit    (segLimit),
    .segGran     (segGran),
    .v86Mode     (v86Mode),
    .effAddr     (effAddr),
    .baseReg     (baseReg),
    .baseRegUsed (baseRegUsed),
    .linAddr     (linAddr),
    .fault       (fault)
  );

  agen16_csdec u_csdec (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .v86Mode   (v86Mode),
    .csIsCode  (csIsCode),
    .csLong    (csLong),
    .csDefault (csDefault),
    .addrSize  (addrSize),
    .opSize    (opSize),
    .csBad     (csBad)
  );

endmodule

// File: tb/agen16_tb.sv
`timescale 1ns/1ps
module agen16_tb;

  localparam real CLK_NS = 4.0;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [7:0]   modrm = '0;
  logic [15:0]  disp = '0;
  logic [127:0] regFile = '0;
  logic [15:0]  segSel = '0;
  logic [31:0]  segBase = '0;
  logic [19:0]  segLimit = '0;
  logic         segGran = 1'b0;
  logic         v86Mode = 1'b0;
  logic         csIsCode = 1'b0;
  logic         csLong = 1'b0;
  logic         csDefault = 1'b0;
  logic         outValid, baseRegUsed, fault, csBad;
  logic [15:0]  effAddr;
  logic [2:0]   baseReg;
  logic [31:0]  linAddr;
  logic [1:0]   addrSize, opSize;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] rv [8];

  always #(CLK_NS/2) clk = ~clk;

  agen16 u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modrm(modrm), .disp(disp),
    .regFile(regFile), .segSel(segSel), .segBase(segBase), .segLimit(segLimit),
    .segGran(segGran), .v86Mode(v86Mode), .csIsCode(csIsCode), .csLong(csLong),
    .csDefault(csDefault), .outValid(outValid), .effAddr(effAddr),
    .baseReg(baseReg), .baseRegUsed(baseRegUsed), .linAddr(linAddr),
    .fault(fault), .addrSize(addrSize), .opSize(opSize), .csBad(csBad)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadRegs();
    for (int i = 0; i < 8; i++) regFile[16*i +: 16] = rv[i];
  endtask

  // Apply one request at the falling edge, sample one cycle later
  task automatic issue();
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int firstCode(input int rm);
    case (rm)
      0, 1, 7: return 3;
      2, 3, 6: return 5;
      4:       return 6;
      default: return 7;
    endcase
  endfunction

  // Expected address result, built from R1..R9
  task automatic checkAddr(input string ctx);
    int mo, rm;
    longint sum, lim, lin;
    bit expFault, used;
    logic [15:0] ea;
    mo = modrm[7:6];
    rm = modrm[2:0];
    if (mo == 3) begin
      chk(fault == 1'b1, {"R5 fault ", ctx}, 32'(fault), 1);
      chk(effAddr == 0 && linAddr == 0 && !baseRegUsed, {"R5 zero ", ctx},
          linAddr, 0);
      return;
    end
    used = !(mo == 0 && rm == 6);
    sum = 0;
    if (used) sum += rv[firstCode(rm)];
    if (rm < 4) sum += rv[(rm % 2 == 1) ? 7 : 6];
    if (mo != 0 || !used) sum += disp;
    ea = 16'(sum % 65536);
    lim = segGran ? (longint'(segLimit) * 4096 + 4095) : longint'(segLimit);
    expFault = !v86Mode && ((longint'(ea) > lim) || segSel == 0);
    if (expFault) lin = 0;
    else if (v86Mode) lin = (longint'(segSel) * 16 + ea) % (64'd1 << 20);
    else lin = (longint'(segBase) + ea) % (64'd1 << 32);
    chk(effAddr == ea, {"R1/R3 effAddr ", ctx}, 32'(effAddr), 32'(ea));
    chk(baseRegUsed == used, {"R2 used ", ctx}, 32'(baseRegUsed), 32'(used));
    if (used) chk(baseReg == 3'(firstCode(rm)), {"R4 baseReg ", ctx},
                  32'(baseReg), 32'(firstCode(rm)));
    chk(fault == expFault, {"R6/R7 fault ", ctx}, 32'(fault), 32'(expFault));
    chk(linAddr == 32'(lin), {"R8/R9 linAddr ", ctx}, linAddr, 32'(lin));
    chk(outValid == 1'b1, {"R12 valid ", ctx}, 32'(outValid), 1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!outValid && effAddr == 0 && linAddr == 0 && !fault && !csBad &&
        addrSize == 0 && opSize == 0 && !baseRegUsed, "R12 reset", linAddr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep all addressing bytes, two register sets, both modes
    for (int set = 0; set < 2; set++) begin
      for (int i = 0; i < 8; i++)
        rv[i] = (set == 0) ? 16'(16'h1111 * (i + 1)) : 16'(16'hF00D + i * 16'h2345);
      loadRegs();
      for (int m = 0; m < 2; m++) begin
        for (int b = 0; b < 256; b++) begin
          modrm = 8'(b);
          disp = 16'(16'h0123 + b * 16'h0101);
          segSel = 16'h2468;
          segBase = 32'h0001_0000 + 32'(set);
          segLimit = 20'hFFFFF;
          segGran = 1'b1;
          v86Mode = 1'(m);
          issue();
          checkAddr($sformatf("sweep set%0d v86=%0d modrm=%02h", set, m, b));
        end
      end
    end

    // R6: limit boundary without granularity, displacement-only form
    modrm = 8'h06; v86Mode = 0; segSel = 16'h0008; segBase = 32'h1000_0000;
    segGran = 0; segLimit = 20'h01234;
    disp = 16'h1234; issue(); checkAddr("R6 at limit");
    disp = 16'h1235; issue(); checkAddr("R6 limit+1");
    chk(fault == 1'b1, "R6 over limit", 32'(fault), 1);
    // R6: granularity boundary
    segGran = 1; segLimit = 20'h0;
    disp = 16'h0FFF; issue(); checkAddr("R6 gran at limit");
    chk(fault == 1'b0, "R6 gran edge legal", 32'(fault), 0);
    disp = 16'h1000; issue(); checkAddr("R6 gran limit+1");
    chk(fault == 1'b1, "R6 gran over", 32'(fault), 1);
    // R8: same offset in v86 does not fault
    v86Mode = 1; issue(); checkAddr("R8 no limit");
    chk(fault == 1'b0, "R8 no limit fault", 32'(fault), 0);

    // R1: 16-bit wrap keeps sum under a small limit
    for (int i = 0; i < 8; i++) rv[i] = 16'h0;
    rv[3] = 16'hFFFF; rv[6] = 16'h0002; loadRegs();
    v86Mode = 0; modrm = 8'h00; segGran = 0; segLimit = 20'h00010; disp = 16'h7777;
    issue(); checkAddr("R1 wrap");
    chk(effAddr == 16'h0001 && !fault, "R1 wrap value", 32'(effAddr), 1);
    chk(effAddr == 16'h0001, "R3 mod0 ignores disp", 32'(effAddr), 1);

    // R7: null selector
    segSel = 16'h0; segLimit = 20'hFFFFF; issue(); checkAddr("R7 null prot");
    chk(fault == 1'b1, "R7 null fault", 32'(fault), 1);
    v86Mode = 1; issue(); checkAddr("R7 null ignored v86");

    // R8: 20-bit wrap in v86
    segSel = 16'hFFFF; modrm = 8'h06; disp = 16'hFFFF; issue();
    chk(linAddr == 32'h0000_FFEF, "R8 wrap 20 bits", linAddr, 32'h0000_FFEF);
    // R9: protected 32-bit base wrap
    v86Mode = 0; segSel = 16'h0010; segBase = 32'hFFFF_FFF0; disp = 16'h0020;
    issue();
    chk(linAddr == 32'h0000_0010, "R9 base wrap", linAddr, 32'h10);

    // R10/R11: code-segment decode crossed with mode
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        logic [1:0] ea, eo;
        bit eb;
        v86Mode = 1'(m); csIsCode = c[2]; csLong = c[1]; csDefault = c[0];
        issue();
        ea = 0; eo = 0; eb = 0;
        if (m == 0) begin
          if (!c[2]) eb = 1;
          else case (c[1:0])
            0: begin ea = 0; eo = 0; end
            1: begin ea = 1; eo = 1; end
            2: begin ea = 2; eo = 1; end
            default: eb = 1;
          endcase
        end
        chk(addrSize == ea && opSize == eo, $sformatf("R10 sizes v86=%0d c=%0d", m, c),
            32'({addrSize, opSize}), 32'({ea, eo}));
        chk(csBad == eb, $sformatf("R11 csBad v86=%0d c=%0d", m, c),
            32'(csBad), 32'(eb));
      end
    end

    // R12: hold when no load
    v86Mode = 0; segSel = 16'h0010; segBase = 32'h0; modrm = 8'h06;
    disp = 16'h00AA; issue();
    inValid = 1'b0; disp = 16'h5555; modrm = 8'hC0;
    @(posedge clk); @(negedge clk);
    chk(!outValid, "R12 valid drops", 32'(outValid), 0);
    chk(effAddr == 16'h00AA && !fault, "R12 hold", 32'(effAddr), 32'h00AA);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule